// File: doc/BRIEF.md
# Saturating Loadable Countdown Register

This block is a down-counter of parameterized width that a 2-bit command steers on every rising clock edge. The command either copies the data input into the count, lowers the count by one, or leaves it as it is. The count never wraps. A decrement command issued while the count is zero leaves it at zero.

The count itself is not visible outside the block. The only output is a combinational flag that reads 1 whenever the count is zero. A typical use is to load a cycle budget, issue decrement commands, and watch the flag to see when the budget has run out. An active-high reset clears the count at once, without waiting for a clock edge.

Internally the command is mapped to one of three named operations, LOAD, DECREMENT and KEEP. A small state register applies the chosen operation. The transitions are: LOAD, any count goes to the data input. DECREMENT, a count above zero goes to that count minus one. KEEP, the count stays unchanged. A decrement command at zero becomes KEEP, which is where the saturation comes from.

Top module: `sat_countdown`

## Requirements
- R1: While `rst_i` is 1 the count is zero and `zero_o` is 1. Reset takes effect at once, not at a clock edge.
- R2: The count width is set by parameter `CNT_W`, default 8. With the default, a load of 255 needs exactly 255 decrements before `zero_o` rises.
- R3: Command code 2'b00 (load) copies `data_i` into the count on the rising clock edge.
- R4: Command code 2'b01 (decrement) lowers a nonzero count by exactly one on the rising clock edge.
- R5: Command code 2'b01 applied while the count is zero leaves the count at zero. It never wraps to the maximum value.
- R6: Command code 2'b10 (keep) leaves the count unchanged.
- R7: The unused command code 2'b11 acts as keep and leaves the count unchanged.
- R8: `zero_o` is 1 exactly when the count is zero. Take a load of N > 0 followed by decrements. `zero_o` then reads 0 after the load edge and after each of the first N-1 decrement edges. It reads 1 after the N-th decrement edge and after every later one.
- R9: A load of zero sets `zero_o` to 1 after that single clock edge, with no decrement needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count changes on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset; clears the count |
| cmd_i | input | 2 | Command: 00 load, 01 decrement, 10 keep, 11 keep |
| data_i | input | CNT_W | Value copied into the count by a load command |
| zero_o | output | 1 | 1 when the count is zero |

## Verification
The hardest situation to reach from the ports is the edge of saturation: the step from one to zero, followed by further decrements that must not wrap to the all-ones value. A long run starting from a full-scale load is needed as well, to show the width is honoured. Since the count is hidden, the keep and reserved codes can only be seen through their effect on later cycles. The stimulus therefore loads a known value, applies keep commands, then counts down exactly that many steps and watches the flag rise on the expected edge. Random command streams with small load values reach zero and saturate often. Directed runs cover the 255-step count-down, a load of zero and a reset asserted in the middle of a cycle.

// File: rtl/cd_pkg.sv
package cd_pkg;

    // External command encoding seen on cmd_i
    typedef enum logic [1:0] {
        CMD_LOAD = 2'b00,
        CMD_DEC  = 2'b01,
        CMD_KEEP = 2'b10,
        CMD_RSVD = 2'b11
    } cd_cmd_e;

    // Internal operation applied to the count state
    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_LOAD = 2'b01,
        OP_DEC  = 2'b10
    } cd_op_e;

endpackage

// File: rtl/cd_decode.sv
module cd_decode
    import cd_pkg::*;
(
    input  logic [1:0] cmd_i,
    input  logic       is_zero_i,
    output cd_op_e     op_o
);

    cd_cmd_e cmd;
    assign cmd = cd_cmd_e'(cmd_i);

    always_comb begin
        unique case (cmd)
            CMD_LOAD: op_o = OP_LOAD;
            CMD_DEC:  op_o = is_zero_i ? OP_KEEP : OP_DEC;  // saturate at zero
            CMD_KEEP: op_o = OP_KEEP;
            CMD_RSVD: op_o = OP_KEEP;                       // reserved code keeps
            default:  op_o = OP_KEEP;
        endcase
    end

endmodule

// File: rtl/cd_store.sv
module cd_store
    import cd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  cd_op_e           op_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        unique case (op_i)
            OP_LOAD: count_d = data_i;
            OP_DEC:  count_d = count_q - ONE;
            OP_KEEP: count_d = count_q;
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/cd_zero.sv
module cd_zero #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             zero_o
);

    assign zero_o = (count_i == '0);

endmodule

// File: rtl/sat_countdown.sv
module sat_countdown
    import cd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       cmd_i,
    input  logic [CNT_W-1:0] data_i,
    output logic             zero_o
);

    cd_op_e           op;
    logic [CNT_W-1:0] count_q;
    logic             is_zero;

    cd_decode u_decode (
        .cmd_i     (cmd_i),
        .is_zero_i (is_zero),
        .op_o      (op)
    );

    cd_store #(.CNT_W(CNT_W)) u_store (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .op_i    (op),
        .data_i  (data_i),
        .count_o (count_q)
    );

    cd_zero #(.CNT_W(CNT_W)) u_zero (
        .count_i (count_q),
        .zero_o  (is_zero)
    );

    assign zero_o = is_zero;

endmodule

// File: rtl/cd_checker.sv
module cd_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [1:0]       cmd_i,
    input logic [CNT_W-1:0] data_i,
    input logic [CNT_W-1:0] count_q,
    input logic             zero_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1: reset forces zero count and a raised flag
    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |-> (count_q == '0 && zero_o));

    // R3: load copies the data input
    a_r3_load_takes_data: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == 2'b00) |=> (count_q == $past(data_i)));

    // R4: decrement of a nonzero count lowers it by one
    a_r4_dec_by_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == 2'b01 && count_q != '0) |=> (count_q == $past(count_q) - ONE));

    // R5: decrement at zero stays at zero
    a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == 2'b01 && count_q == '0) |=> (count_q == '0));

    // R6: keep code leaves the count alone
    a_r6_keep_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == 2'b10) |=> $stable(count_q));

    // R7: reserved code leaves the count alone
    a_r7_rsvd_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == 2'b11) |=> $stable(count_q));

    // R8: flag agrees with the count
    a_r8_flag_matches: assert property (@(posedge clk_i) disable iff (rst_i)
        zero_o == (count_q == '0));

endmodule

bind sat_countdown cd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cmd_i   (cmd_i),
    .data_i  (data_i),
    .count_q (count_q),
    .zero_o  (zero_o)
);

// File: tb/sat_countdown_tb.sv
module sat_countdown_tb;

    localparam int W = 8;
    localparam int WATCHDOG_NS = 400000;

    logic         clk;
    logic         rst;
    logic [1:0]   cmd;
    logic [W-1:0] data;
    logic         zero;

    int checks;
    int fails;
    int model;

    sat_countdown #(.CNT_W(W)) u_dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .cmd_i  (cmd),
        .data_i (data),
        .zero_o (zero)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    function automatic int next_model(input logic [1:0] c, input int d, input int cur);
        case (c)
            2'b00:   return d;
            2'b01:   return (cur > 0) ? cur - 1 : 0;
            default: return cur;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: zero_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] c, input int d, input string req);
        @(negedge clk);
        cmd  = c;
        data = W'(d);
        @(posedge clk);
        model = next_model(c, d, model);
        #1;
        chk(req, zero, logic'(model == 0));
    endtask

    initial begin
        #WATCHDOG_NS;
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        checks = 0;
        fails  = 0;
        model  = 0;
        rst    = 1'b1;
        cmd    = 2'b10;
        data   = '0;
        #1;
        chk("R1", zero, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 / R8: load 13 then count down; flag rises on the 13th decrement
        step(2'b00, 13, "R3");
        for (int i = 0; i < 13; i++) step(2'b01, 0, "R8/R4");
        // R5: further decrements stay at zero
        for (int i = 0; i < 10; i++) step(2'b01, 0, "R5");

        // R9: load zero raises the flag directly
        step(2'b00, 5, "R3");
        step(2'b00, 0, "R9");

        // R6: keep holds value 3
        step(2'b00, 3, "R3");
        for (int i = 0; i < 6; i++) step(2'b10, 200, "R6");
        for (int i = 0; i < 3; i++) step(2'b01, 0, "R6");

        // R7: reserved code holds value 2
        step(2'b00, 2, "R3");
        for (int i = 0; i < 6; i++) step(2'b11, 0, "R7");
        for (int i = 0; i < 3; i++) step(2'b01, 0, "R7");

        // R2: full-scale load needs 255 decrements
        step(2'b00, 255, "R2");
        for (int i = 0; i < 256; i++) step(2'b01, 0, "R2");

        // R1: asynchronous reset in mid-cycle
        step(2'b00, 9, "R3");
        @(negedge clk);
        cmd = 2'b10;
        #1;
        rst = 1'b1;
        #0.5;
        chk("R1", zero, 1'b1);
        model = 0;
        @(negedge clk);
        rst = 1'b0;

        // Random mix with small loads
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [1:0] c;
            int d;
            r = int'($urandom % 10);
            if (r < 2)      c = 2'b00;
            else if (r < 7) c = 2'b01;
            else if (r < 9) c = 2'b10;
            else            c = 2'b11;
            d = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 6);
            step(c, d, "R8");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule